// File: doc/BRIEF.md
# Single-Wire Pulse-Count Level Programmer

This block turns one control line into two things: an enable for a negative supply rail and a 5-bit setting code that selects the rail's target level. The line is sampled on the system clock through a synchronizer and a deglitch filter. Taking the line high enables the rail at once with the default code. After a settling window, every rising edge on the line adds one to a saturating pulse counter. When the line has then stayed high for a store window, the count becomes the new setting code and the counter starts again from zero.

Holding the line low for the shutdown window disables the rail and returns the code to its default. Shorter low phases are treated as gaps between pulses. Along with the code, the block outputs a one-cycle strobe each time a code is applied, and the target level in tenths of a volt as a signed number. All windows are parameters counted in clock cycles.

Top module: `pulse_level_prog`

## Requirements
- R1: During and after reset with the line low, `rail_en_o` is 0, `set_code_o` is 0, `apply_stb_o` is 0 and `level_dv_o` is -49.
- R2: A filtered high level on the line while disabled sets `rail_en_o` to 1 and applies code 0 with one `apply_stb_o` pulse.
- R3: Rising edges that arrive within `INIT_CYC` filtered cycles of enable are ignored. No code is committed from them.
- R4: After the settling window, each filtered rising edge adds one to the pulse count. The count is committed to `set_code_o` once the line has been high for `STORE_CYC` cycles after the last edge. Three edges give code 3, which is level -50.
- R5: `level_dv_o` follows the committed code as follows. Code 0 gives -49. Code c from 1 to 31 gives c-53. So code 1 gives -52, code 4 gives -49 and code 31 gives -22.
- R6: Each commit raises `apply_stb_o` for exactly one cycle. While the rail stays enabled, `set_code_o` changes only in a cycle with the strobe.
- R7: After a commit the pulse count restarts at zero, so a following burst of k edges commits code k and not a sum.
- R8: A burst of more than 31 edges commits code 31. The count saturates instead of wrapping.
- R9: A low phase of `OFF_CYC` filtered cycles disables the rail (`rail_en_o` 0, code 0, level -49). A shorter low phase is a pulse gap, and the edge that ends it counts.
- R10: Line glitches shorter than `FILT_LEN` cycles change neither the count nor the rail state. Pulses whose high and low phases are each at least `FILT_LEN`+2 cycles are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_line_i | input | 1 | Asynchronous combined enable and pulse-programming line |
| rail_en_o | output | 1 | Rail enable |
| set_code_o | output | 5 | Committed setting code |
| apply_stb_o | output | 1 | One-cycle pulse when a code is applied |
| level_dv_o | output | 7 | Signed target level in tenths of a volt |

## Verification
The assertions assume that any real pulse holds each phase for at least `FILT_LEN`+2 cycles, and that pulse phases stay shorter than both the store window and the shutdown window. Only then is each edge seen once, and is no burst split by an early commit or an accidental shutdown. The random stimulus draws phase widths between 6 and 20 cycles while the store and shutdown windows are 50 and 60 cycles, so it stays inside this envelope. Only the deliberate glitch test drives one-cycle phases, and it checks that they are rejected.

// File: rtl/plp_pkg.sv
package plp_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_WAIT = 2'd1,
    PH_RUN  = 2'd2
  } plp_phase_e;

  localparam int DEFAULT_DV = -49;
  localparam int BASE_DV    = -53;
endpackage

// File: rtl/plp_line_filter.sv
module plp_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      lvl_o  <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      rise_o <= 1'b0;
      if (&hist_q) begin
        lvl_o  <= 1'b1;
        rise_o <= !lvl_o;
      end else if (~|hist_q) begin
        lvl_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/plp_window_timer.sv
module plp_window_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)                       cnt_q <= '0;
    else if (run_i && cnt_q != CW'(LIMIT))    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/plp_level_map.sv
module plp_level_map #(
  parameter int CODE_W = 5,
  parameter int LVL_W  = 7
) (
  input  logic [CODE_W-1:0]       code_i,
  output logic signed [LVL_W-1:0] level_o
);
  import plp_pkg::*;
  localparam logic signed [LVL_W-1:0] DEF_L  = LVL_W'(DEFAULT_DV);
  localparam logic signed [LVL_W-1:0] BASE_L = LVL_W'(BASE_DV);

  always_comb begin
    if (code_i == '0) level_o = DEF_L;
    else              level_o = BASE_L + $signed({{(LVL_W-CODE_W){1'b0}}, code_i});
  end
endmodule

// File: rtl/pulse_level_prog.sv
module pulse_level_prog #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int INIT_CYC    = 40,
  parameter int OFF_CYC     = 60,
  parameter int STORE_CYC   = 50,
  parameter int CODE_W      = 5,
  parameter int LVL_W       = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctrl_line_i,
  output logic                    rail_en_o,
  output logic [CODE_W-1:0]       set_code_o,
  output logic                    apply_stb_o,
  output logic signed [LVL_W-1:0] level_dv_o
);
  import plp_pkg::*;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic signed [LVL_W-1:0] DEF_L = LVL_W'(DEFAULT_DV);

  logic lvl, rise;
  logic off_done, init_done, store_done;
  plp_phase_e phase_q, phase_n;
  logic [CODE_W-1:0] pulse_cnt, pulse_n, code_n;
  logic pending_q, pending_n, en_n, stb_n;
  logic signed [LVL_W-1:0] level_n;

  plp_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .line_i(ctrl_line_i), .lvl_o(lvl), .rise_o(rise)
  );

  plp_window_timer #(.LIMIT(OFF_CYC)) u_off_tmr (
    .clk(clk), .rst(rst),
    .clear_i(lvl || phase_q == PH_OFF),
    .run_i(!lvl && phase_q != PH_OFF),
    .done_o(off_done)
  );

  plp_window_timer #(.LIMIT(INIT_CYC)) u_init_tmr (
    .clk(clk), .rst(rst),
    .clear_i(phase_q != PH_WAIT),
    .run_i(phase_q == PH_WAIT),
    .done_o(init_done)
  );

  plp_window_timer #(.LIMIT(STORE_CYC)) u_store_tmr (
    .clk(clk), .rst(rst),
    .clear_i(rise || !lvl || !pending_q || phase_q != PH_RUN),
    .run_i(lvl && pending_q && phase_q == PH_RUN),
    .done_o(store_done)
  );

  plp_level_map #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_map (
    .code_i(code_n), .level_o(level_n)
  );

  always_comb begin
    phase_n   = phase_q;
    pulse_n   = pulse_cnt;
    pending_n = pending_q;
    code_n    = set_code_o;
    en_n      = rail_en_o;
    stb_n     = 1'b0;
    unique case (phase_q)
      PH_OFF: begin
        if (lvl) begin
          phase_n   = PH_WAIT;
          en_n      = 1'b1;
          code_n    = '0;
          stb_n     = 1'b1;
          pulse_n   = '0;
          pending_n = 1'b0;
        end
      end
      PH_WAIT: begin
        if (off_done)       phase_n = PH_OFF;
        else if (init_done) phase_n = PH_RUN;
      end
      PH_RUN: begin
        if (off_done) begin
          phase_n = PH_OFF;
        end else if (rise) begin
          pending_n = 1'b1;
          if (pulse_cnt != CODE_MAX) pulse_n = pulse_cnt + 1'b1;
        end else if (store_done && pending_q) begin
          code_n    = pulse_cnt;
          stb_n     = 1'b1;
          pulse_n   = '0;
          pending_n = 1'b0;
        end
      end
      default: phase_n = PH_OFF;
    endcase
    if (phase_q != PH_OFF && phase_n == PH_OFF) begin
      en_n      = 1'b0;
      code_n    = '0;
      pulse_n   = '0;
      pending_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_OFF;
      pulse_cnt   <= '0;
      pending_q   <= 1'b0;
      rail_en_o   <= 1'b0;
      set_code_o  <= '0;
      apply_stb_o <= 1'b0;
      level_dv_o  <= DEF_L;
    end else begin
      phase_q     <= phase_n;
      pulse_cnt   <= pulse_n;
      pending_q   <= pending_n;
      rail_en_o   <= en_n;
      set_code_o  <= code_n;
      apply_stb_o <= stb_n;
      level_dv_o  <= level_n;
    end
  end
endmodule

// File: rtl/plp_checker.sv
module plp_checker #(
  parameter int CODE_W = 5,
  parameter int LVL_W  = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rail_en_o,
  input logic [CODE_W-1:0]       set_code_o,
  input logic                    apply_stb_o,
  input logic signed [LVL_W-1:0] level_dv_o,
  input logic [CODE_W-1:0]       pulse_cnt
);
  localparam logic [CODE_W-1:0] CMAX = '1;

  AST_OFF_CODE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    !rail_en_o |-> (set_code_o == '0 && !apply_stb_o)); // R9

  AST_ENABLE_APPLIES_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_en_o) |-> (apply_stb_o && set_code_o == '0)); // R2

  AST_LEVEL_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (set_code_o == '0) |-> (level_dv_o == -7'sd49)); // R5

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (set_code_o != '0) |->
      (level_dv_o == $signed({{(LVL_W-CODE_W){1'b0}}, set_code_o}) - 7'sd53)); // R5

  AST_CODE_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (rail_en_o && $past(rail_en_o) && !apply_stb_o) |-> $stable(set_code_o)); // R6

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    apply_stb_o |=> !apply_stb_o); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($past(pulse_cnt) == CMAX && pulse_cnt != '0) |-> (pulse_cnt == CMAX)); // R8

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (apply_stb_o && rail_en_o) |-> (pulse_cnt == '0)); // R7
endmodule

bind pulse_level_prog plp_checker #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_plp_chk (
  .clk(clk), .rst(rst), .rail_en_o(rail_en_o), .set_code_o(set_code_o),
  .apply_stb_o(apply_stb_o), .level_dv_o(level_dv_o), .pulse_cnt(pulse_cnt)
);

// File: tb/tb_pulse_level_prog.sv
module tb_pulse_level_prog;
  localparam int INIT_C = 40, OFF_C = 60, STORE_C = 50;

  logic clk = 1'b0, rst = 1'b1, line = 1'b0;
  logic rail_en_o, apply_stb_o;
  logic [4:0] set_code_o;
  logic signed [6:0] level_dv_o;
  int n_tests = 0, n_fail = 0, stb_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pulse_level_prog #(.INIT_CYC(INIT_C), .OFF_CYC(OFF_C), .STORE_CYC(STORE_C)) dut (
    .clk(clk), .rst(rst), .ctrl_line_i(line), .rail_en_o(rail_en_o),
    .set_code_o(set_code_o), .apply_stb_o(apply_stb_o), .level_dv_o(level_dv_o)
  );

  always @(posedge clk) if (!rst && apply_stb_o) stb_cnt++;

  function automatic int exp_level(int code);
    return (code == 0) ? -49 : code - 53;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic burst(int n, int hmin, int hmax);
    for (int i = 0; i < n; i++) begin
      line = 1'b0; tick($urandom_range(hmax, hmin));
      line = 1'b1; tick($urandom_range(hmax, hmin));
    end
  endtask

  task automatic program_and_check(string req, int n, int exp_code);
    int s0;
    s0 = stb_cnt;
    burst(n, 6, 20);
    tick(STORE_C + 20);
    check({req, " code"}, set_code_o, exp_code);
    check({req, " level"}, level_dv_o, exp_level(exp_code));
    check({req, " one strobe"}, stb_cnt - s0, 1);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd4242));
    tick(5);
    // R1 reset state
    check("R1 en", rail_en_o, 0);
    check("R1 code", set_code_o, 0);
    check("R1 strobe", apply_stb_o, 0);
    check("R1 level", level_dv_o, -49);
    rst = 1'b0;
    tick(10);
    check("R1 idle en", rail_en_o, 0);

    // R2 enable with default, R3 pulses inside settling window ignored
    s0 = stb_cnt;
    line = 1'b1; tick(8);
    check("R2 en", rail_en_o, 1);
    burst(2, 6, 6);
    tick(STORE_C + INIT_C);
    check("R2 strobe", stb_cnt - s0, 1);
    check("R3 code after init pulses", set_code_o, 0);
    check("R2 level", level_dv_o, -49);

    // R4 three edges give -5.0 V
    program_and_check("R4", 3, 3);
    // R7 fresh count
    program_and_check("R7", 2, 2);
    // R5 boundary codes
    program_and_check("R5 c1", 1, 1);
    program_and_check("R5 c4", 4, 4);
    program_and_check("R5 c31", 31, 31);
    // R8 saturation
    program_and_check("R8", 36, 31);

    // R10 minimum width pulses
    s0 = stb_cnt;
    burst(5, 5, 5);
    tick(STORE_C + 20);
    check("R10 min width code", set_code_o, 5);
    check("R10 min width strobe", stb_cnt - s0, 1);

    // R10 glitches rejected
    s0 = stb_cnt;
    for (int i = 0; i < 4; i++) begin
      line = 1'b0; tick(1); line = 1'b1; tick(10);
    end
    tick(STORE_C + 20);
    check("R10 glitch code", set_code_o, 5);
    check("R10 glitch strobe", stb_cnt - s0, 0);
    check("R10 glitch en", rail_en_o, 1);

    // R6 random bursts
    for (int t = 0; t < 8; t++) begin
      int n;
      n = $urandom_range(31, 1);
      program_and_check("R6 random", n, n);
    end

    // R9 short low is a gap
    line = 1'b0; tick(OFF_C - 20);
    line = 1'b1; tick(STORE_C + 20);
    check("R9 gap en", rail_en_o, 1);
    check("R9 gap code", set_code_o, 1);

    // R9 long low shuts down
    program_and_check("R9 pre", 7, 7);
    line = 1'b0; tick(OFF_C + 20);
    check("R9 off en", rail_en_o, 0);
    check("R9 off code", set_code_o, 0);
    check("R9 off level", level_dv_o, -49);

    // R2 re-enable restarts at default
    s0 = stb_cnt;
    line = 1'b1; tick(INIT_C + 20);
    check("R2 re-enable en", rail_en_o, 1);
    check("R2 re-enable code", set_code_o, 0);
    check("R2 re-enable strobe", stb_cnt - s0, 1);
    program_and_check("R4 after re-enable", 3, 3);

    finished = 1;
    summary();
    $finish;
  end
endmodule